// File: doc/BRIEF.md
# Pulse Period and Duty Capture Timer

This block times the pulses on a single serial input line, such as the output of an infrared receiver. A prescaler turns the system clock into a slow counting tick, 1 µs by default. A counter advances on each tick. An arm request makes the block listen. The next falling edge of the line starts a measurement burst and zeroes both the counter and the prescaler.

While the burst runs, each rising edge publishes three values and then restarts the count:
- the elapsed count as the period;
- the count held at the last falling edge as the high time;
- their difference as the low time.

A one-cycle capture strobe marks each new set of values. If the count reaches a programmable limit with no rising edge, the block raises a one-cycle timeout strobe and the counter wraps. If the line is then high, the burst is over and the block disarms. If the line is low, the burst goes on.

Before any edge is detected, the line passes through a two-flop synchronizer and a glitch filter. Decoding the captured pulse widths into frames is left to the logic that consumes them.

Top module: `pulse_cap_timer`

## Requirements
- R1: After reset, period_o, high_o and low_o are 0, cap_o and timeout_o are low, and the block is disarmed.
- R2: While disarmed, line edges produce no capture strobe and no timeout strobe.
- R3: After arm_i is seen high for a cycle, the next filtered falling edge of the line starts a burst. The first rising edge that follows reports as its period the ticks since that falling edge, with high_o = 0 and low_o = period_o.
- R4: In a burst, each filtered rising edge pulses cap_o high for exactly one cycle. It also sets period_o to the whole ticks counted since the previous rising edge, and restarts the counter and the prescaler.
- R5: On each capture, high_o is the tick count at the falling edge inside the measured interval, and low_o equals period_o minus high_o.
- R6: period_o, high_o and low_o change only in a cycle where cap_o is high. A falling edge alone leaves them unchanged.
- R7: If LIMIT ticks pass with no rising edge and the filtered line is high, timeout_o pulses for one cycle and the block disarms. Later edges are then ignored until arm_i is asserted again.
- R8: If the timeout is reached while the filtered line is low, timeout_o pulses and the counter wraps to 0, but the block stays armed. The next rising edge reports the ticks counted since the wrap.
- R9: A level on the line that lasts fewer than FILT_LEN clock cycles is ignored. It neither produces an edge nor disturbs the timing of the burst.
- R10: One tick is TICK_DIV clock cycles. An interval of N clock cycles between two edges counts floor((N-1)/TICK_DIV) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw serial input line, idle high |
| arm_i | input | 1 | Request to listen for the falling edge that starts a burst |
| period_o | output | CW | Ticks between the last two rising edges |
| high_o | output | CW | High time within the last captured interval |
| low_o | output | CW | Low time within the last captured interval |
| cap_o | output | 1 | One-cycle strobe on each new capture |
| timeout_o | output | 1 | One-cycle strobe when the tick limit is reached |

## Verification
The bench drives edges spaced half a tick past whole tick boundaries. A prescaler that is not restarted on a rising edge, or that is off by one, then shows up as a period one tick away from the expected value.

A low glitch shorter than the filter length is placed inside a high level. A weak filter would report an extra capture or a shortened high time.

The timeout is exercised with the line high and with the line low. A design that always disarms would miss the capture that follows a timeout with the line low. A design that never disarms would keep capturing after the line has gone idle.

The published values are also checked after a falling edge but before the next rising edge. A design that exposes the high time as soon as it is latched would fail that check.

// File: rtl/pulse_cap_pkg.sv
package pulse_cap_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/pulse_cap_filter.sv
module pulse_cap_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int RW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    sync_q;
  logic          filt_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      run_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (sync_q[1] == filt_q) begin
        run_q <= '0;
      end else if (run_q == RW'(FILT_LEN - 1)) begin
        // new level held for FILT_LEN samples
        filt_q <= sync_q[1];
        run_q  <= '0;
        rise_o <= sync_q[1];
        fall_o <= ~sync_q[1];
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = filt_q;

  assert_filter_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> $past(run_q) == RW'(FILT_LEN - 1));

  assert_edge_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/pulse_cap_tick.sv
module pulse_cap_tick #(
  parameter int TICK_DIV = 72
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          pre_q <= '0;
        else if (clr_i || !en_i)              pre_q <= '0;
        else if (pre_q == PW'(TICK_DIV - 1))  pre_q <= '0;
        else                                  pre_q <= pre_q + 1'b1;
      end

      assign tick_o = en_i && !clr_i && (pre_q == PW'(TICK_DIV - 1));

      assert_tick_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end else begin : g_nodiv
      assign tick_o = en_i && !clr_i;
    end
  endgenerate
endmodule

// File: rtl/pulse_cap_timer.sv
module pulse_cap_timer
  import pulse_cap_pkg::*;
#(
  parameter int TICK_DIV = 72,
  parameter int LIMIT    = 18000,
  parameter int FILT_LEN = 4,
  parameter int CW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic          arm_i,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] high_o,
  output logic [CW-1:0] low_o,
  output logic          cap_o,
  output logic          timeout_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  cap_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] hpend_q;
  logic          level, rise_ev, fall_ev, tick, restart;

  pulse_cap_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .level_o(level),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  assign restart = (st_q == ST_WAIT && fall_ev) || (st_q == ST_RUN && rise_ev);

  pulse_cap_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q == ST_RUN),
    .clr_i (restart),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_OFF;
      cnt_q     <= '0;
      hpend_q   <= '0;
      period_o  <= '0;
      high_o    <= '0;
      low_o     <= '0;
      cap_o     <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      cap_o     <= 1'b0;
      timeout_o <= 1'b0;
      unique case (st_q)
        ST_OFF: begin
          cnt_q <= '0;
          if (arm_i) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fall_ev) begin
            st_q    <= ST_RUN;
            cnt_q   <= '0;
            hpend_q <= '0;
          end
        end
        ST_RUN: begin
          if (rise_ev) begin
            period_o <= cnt_q;
            high_o   <= hpend_q;
            low_o    <= cnt_q - hpend_q;
            cap_o    <= 1'b1;
            cnt_q    <= '0;
            hpend_q  <= '0;
          end else begin
            if (fall_ev) hpend_q <= cnt_q;
            if (tick) begin
              if (cnt_q == LAST) begin
                // wrap; R8 keeps the burst alive while the line is low
                cnt_q     <= '0;
                timeout_o <= 1'b1;
                if (level) st_q <= ST_OFF;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assert_cap_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);

  assert_hold_outputs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_o |-> ($stable(period_o) && $stable(high_o) && $stable(low_o)));

  assert_high_in_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> (high_o <= period_o) && (low_o == period_o - high_o));

  assert_disarm_on_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OFF && $past(st_q) == ST_RUN) |-> timeout_o);

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_o && timeout_o));

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: tb/pulse_cap_timer_bench.sv
module pulse_cap_timer_bench;
  localparam int TD = 4;
  localparam int LIM = 100;
  localparam int FL = 4;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b1;
  logic arm = 1'b0;
  logic [CW-1:0] period, high, low;
  logic cap, tmo;

  int checks = 0;
  int fails = 0;
  int cap_cnt = 0;
  int tmo_cnt = 0;
  logic [CW-1:0] last_p = '0, last_h = '0, last_l = '0;

  always #5 clk = ~clk;

  pulse_cap_timer #(.TICK_DIV(TD), .LIMIT(LIM), .FILT_LEN(FL), .CW(CW)) u_pulse_cap_timer (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .arm_i(arm),
    .period_o(period), .high_o(high), .low_o(low), .cap_o(cap), .timeout_o(tmo)
  );

  always @(negedge clk) begin
    if (cap) begin
      cap_cnt <= cap_cnt + 1;
      last_p <= period; last_h <= high; last_l <= low;
    end
    if (tmo) tmo_cnt <= tmo_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic seg(input logic lv, input int ticks);
    line = lv;
    repeat (TD * ticks + 2) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic cap_is(input string req, input int n, input int p, input int h, input int l);
    chk({req, " count"}, cap_cnt, n);
    chk({req, " period"}, last_p, p);
    chk({req, " high"}, last_h, h);
    chk({req, " low"}, last_l, l);
  endtask

  // raise the line and measure cycles until timeout strobe
  task automatic wait_timeout(output int n);
    int t0 = tmo_cnt;
    line = 1'b1;
    n = 0;
    while (tmo_cnt == t0 && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 period", period, 0);
    chk("R1 high", high, 0);
    chk("R1 low", low, 0);
    chk("R1 strobes", {cap, tmo}, 0);
  endtask

  task automatic t_disarmed();
    seg(0, 5); seg(1, 5); seg(0, 3); seg(1, 130);
    chk("R2 no capture", cap_cnt, 0);
    chk("R2 no timeout", tmo_cnt, 0);
  endtask

  task automatic t_burst();
    int n;
    do_arm();
    seg(0, 5); seg(1, 7);
    cap_is("R3 first", 1, 5, 0, 5);
    seg(0, 3); seg(1, 2);
    cap_is("R4 R10 second", 2, 10, 7, 3);
    seg(0, 12);
    chk("R6 high held after fall", high, 7);
    chk("R6 period held after fall", period, 10);
    // R9: 2-cycle low glitch inside a 6-tick high level
    line = 1'b1; repeat (10) @(negedge clk);
    line = 1'b0; repeat (2) @(negedge clk);
    line = 1'b1; repeat (TD * 6 + 2 - 12) @(negedge clk);
    cap_is("R9 R5 glitch ignored", 3, 14, 2, 12);
    seg(0, 4);
    wait_timeout(n);
    cap_is("R5 fourth", 4, 10, 6, 4);
    chk("R7 timeout count", tmo_cnt, 1);
    chk("R7 R10 timeout delay in window", (n >= LIM * TD && n <= LIM * TD + 20) ? 1 : 0, 1);
    seg(0, 5); seg(1, 5); seg(0, 5); seg(1, 5);
    chk("R7 disarmed after timeout", cap_cnt, 4);
    chk("R7 timeout strobe single", tmo_cnt, 1);
  endtask

  task automatic t_low_timeout();
    int n;
    do_arm();
    seg(0, 150);
    chk("R8 timeout while low", tmo_cnt, 2);
    chk("R8 no capture yet", cap_cnt, 4);
    seg(1, 3);
    cap_is("R8 capture after wrap", 5, 50, 0, 50);
    wait_timeout(n);
    chk("R7 final timeout", tmo_cnt, 3);
    seg(0, 4); seg(1, 4);
    chk("R7 ignored after final", cap_cnt, 5);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disarmed();
        t_burst();
        t_low_timeout();
      end
      begin
        repeat (100000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule